// File: doc/BRIEF.md
# ADC Nibble Packer for Wide-Band Raw Capture

This block sits between a pair of 14-bit ADC channels (in-phase and quadrature) and the stream that feeds a packet router. In packed mode it skips digital down-conversion altogether. On every clock it keeps only the top four bits of each raw sample. It then gathers four consecutive I nibbles and four consecutive Q nibbles into one 32-bit word, which has the same shape as an ordinary 16-bit I / 16-bit Q complex sample. One word goes out every fourth clock. The link therefore carries four times as many raw samples as it would in the normal format, at the same word rate. At 100 Msps input that is 25 Mwords/s, so a capture bandwidth of 100 MHz fits where 25 MHz fitted before.

With the mode select low, the block carries the down-converted 16-bit I/Q samples to the same output unchanged. The output is a valid/ready stream held in a single register. If a new word arrives while the held word has not been taken, the new word is lost and a sticky overflow flag is raised. A clear strobe resets the flag. A synchronous start pulse restarts the grouping, so the sample taken in that cycle becomes the oldest nibble of the next word.

Top module: `adc_nibble_packer`

## Requirements
- R1: After reset, `out_valid` and `ovf_flag` are both 0.
- R2: Each packed nibble equals bits [13:10] of its ADC code. Bit 13 is the nibble's sign bit: code 14'h2000 gives 4'h8 and code 14'h3FFF gives 4'hF.
- R3: In a packed word, bits [31:16] hold four I nibbles and bits [15:0] hold four Q nibbles. In each half the oldest sample sits in the top nibble ([15:12] of the half) and the newest sits in [3:0].
- R4: In packed mode with no start pulse, exactly one word completes every fourth clock. It appears on the output after the clock edge that samples its fourth nibble.
- R5: A start pulse in packed mode makes that cycle's samples the top nibbles of the next word. That word completes with the sample three cycles later.
- R6: With `pack_mode`=0, a cycle with `ddc_valid`=1 that is accepted into the output register presents `{ddc_i, ddc_q}` unchanged on `out_data` after the next edge.
- R7: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_data` does not change.
- R8: A word that completes while the output holds an unaccepted word is dropped. `ovf_flag` is set, and the held word is kept.
- R9: `ovf_flag` stays set until `ovf_clr` is pulsed. A clear in a cycle with no new drop gives `ovf_flag`=0 after the edge. If a drop and a clear land in the same cycle, the drop wins.
- R10: In bypass mode the nibble grouping is cleared. The first four packed-mode samples after `pack_mode` rises therefore form one complete word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pack_mode | input | 1 | 1 = packed raw nibbles, 0 = down-converted bypass |
| start | input | 1 | Synchronous restart of nibble grouping |
| adc_i | input | 14 | Raw in-phase ADC code |
| adc_q | input | 14 | Raw quadrature ADC code |
| ddc_i | input | 16 | Down-converted in-phase sample |
| ddc_q | input | 16 | Down-converted quadrature sample |
| ddc_valid | input | 1 | Down-converted sample present |
| out_data | output | 32 | Output word, I half in [31:16] |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the word |
| ovf_flag | output | 1 | Sticky overflow, a word was dropped |
| ovf_clr | input | 1 | Clears the overflow flag |

## Verification
The bench uses negative two's-complement codes such as 14'h2000 and 14'h3FFF. A slicer that took the wrong bits would return the wrong sign nibble on these codes. A reversed shift would place the newest nibble on top, which breaks the fixed pattern 32'h1234_89AF. The bench pulses start in the middle of a word, where a packer that ignores start would emit a mis-aligned word. It also stalls `out_ready` long enough for a second word to complete, so a design that overwrote the held word, or failed to raise the flag, would show the wrong data or a clear `ovf_flag`. Finally it switches out of bypass and checks the first packed word. A counter that was not cleared in bypass would complete that word early.

// File: rtl/packer_pkg.sv
package packer_pkg;
   typedef enum logic {
      MODE_BYPASS = 1'b0,
      MODE_PACKED = 1'b1
   } pack_mode_e;

   function automatic int unsigned half_width(input int unsigned nib_w, input int unsigned lanes);
      return nib_w * lanes;
   endfunction
endpackage

// File: rtl/msb_slicer.sv
module msb_slicer #(
   parameter int unsigned ADC_W = 14,
   parameter int unsigned NIB_W = 4
) (
   input  logic [ADC_W-1:0] sample,
   output logic [NIB_W-1:0] nibble
);
   generate
      if (NIB_W > ADC_W) begin : g_bad_width
         $error("msb_slicer: NIB_W exceeds ADC_W");
      end
      if (NIB_W == ADC_W) begin : g_whole
         assign nibble = sample;
      end else begin : g_top
         assign nibble = sample[ADC_W-1 -: NIB_W];
      end
   endgenerate
endmodule

// File: rtl/lane_packer.sv
module lane_packer #(
   parameter int unsigned NIB_W = 4,
   parameter int unsigned LANES = 4,
   localparam int unsigned HALF_W = NIB_W * LANES,
   localparam int unsigned CW = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              start,
   input  logic [NIB_W-1:0]  nib_i,
   input  logic [NIB_W-1:0]  nib_q,
   output logic              done,
   output logic [HALF_W-1:0] word_i,
   output logic [HALF_W-1:0] word_q
);
   generate
      if (LANES < 2) begin : g_bad_lanes
         $error("lane_packer: LANES must be at least 2");
      end
   endgenerate

   logic [CW-1:0]    cnt;
   logic [NIB_W-1:0] lane_i [LANES-1];
   logic [NIB_W-1:0] lane_q [LANES-1];

   localparam logic [CW-1:0] LAST = CW'(LANES - 1);

   assign done = en && !start && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!en) begin
         cnt <= '0;
      end else if (start) begin
         cnt <= CW'(1);
      end else if (cnt == LAST) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + CW'(1);
      end
   end

   genvar k;
   generate
      for (k = 0; k < LANES - 1; k++) begin : g_lane
         if (k == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  lane_i[k] <= '0;
                  lane_q[k] <= '0;
               end else if (en) begin
                  lane_i[k] <= nib_i;
                  lane_q[k] <= nib_q;
               end
            end
         end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  lane_i[k] <= '0;
                  lane_q[k] <= '0;
               end else if (en) begin
                  lane_i[k] <= lane_i[k-1];
                  lane_q[k] <= lane_q[k-1];
               end
            end
         end
      end
      for (k = 0; k < LANES; k++) begin : g_word
         if (k == 0) begin : g_new
            assign word_i[NIB_W-1:0] = nib_i;
            assign word_q[NIB_W-1:0] = nib_q;
         end else begin : g_old
            assign word_i[(k+1)*NIB_W-1 -: NIB_W] = lane_i[k-1];
            assign word_q[(k+1)*NIB_W-1 -: NIB_W] = lane_q[k-1];
         end
      end
   endgenerate

   // R4: completed words are never back to back
   assert_done_spacing_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/word_holder.sv
module word_holder #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         src_vld,
   input  logic [W-1:0] src_data,
   input  logic         out_ready,
   input  logic         ovf_clr,
   output logic         out_valid,
   output logic [W-1:0] out_data,
   output logic         ovf_flag
);
   logic take;
   logic drop;

   assign take = src_vld && (!out_valid || out_ready);
   assign drop = src_vld && out_valid && !out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (take) begin
         out_valid <= 1'b1;
         out_data  <= src_data;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_flag <= 1'b0;
      end else if (drop) begin
         ovf_flag <= 1'b1;
      end else if (ovf_clr) begin
         ovf_flag <= 1'b0;
      end
   end

   assert_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   assert_drop_flags_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (src_vld && out_valid && !out_ready) |=> ovf_flag);

   assert_ovf_sticky_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

// File: rtl/adc_nibble_packer.sv
module adc_nibble_packer #(
   parameter int unsigned ADC_W = 14,
   parameter int unsigned NIB_W = 4,
   parameter int unsigned LANES = 4,
   parameter int unsigned DDC_W = 16,
   localparam int unsigned HALF_W = packer_pkg::half_width(NIB_W, LANES),
   localparam int unsigned WORD_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pack_mode,
   input  logic              start,
   input  logic [ADC_W-1:0]  adc_i,
   input  logic [ADC_W-1:0]  adc_q,
   input  logic [DDC_W-1:0]  ddc_i,
   input  logic [DDC_W-1:0]  ddc_q,
   input  logic              ddc_valid,
   output logic [WORD_W-1:0] out_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              ovf_flag,
   input  logic              ovf_clr
);
   import packer_pkg::*;

   generate
      if (HALF_W != DDC_W) begin : g_bad_half
         $error("adc_nibble_packer: NIB_W*LANES must equal DDC_W");
      end
   endgenerate

   pack_mode_e       mode;
   logic [NIB_W-1:0] nib_i, nib_q;
   logic             word_done;
   logic [HALF_W-1:0] word_i, word_q;
   logic             src_vld;
   logic [WORD_W-1:0] src_data;

   assign mode = pack_mode_e'(pack_mode);

   msb_slicer #(.ADC_W(ADC_W), .NIB_W(NIB_W)) u_slice_i (
      .sample(adc_i), .nibble(nib_i));
   msb_slicer #(.ADC_W(ADC_W), .NIB_W(NIB_W)) u_slice_q (
      .sample(adc_q), .nibble(nib_q));

   lane_packer #(.NIB_W(NIB_W), .LANES(LANES)) u_pack (
      .clk(clk), .rst_n(rst_n), .en(mode == MODE_PACKED), .start(start),
      .nib_i(nib_i), .nib_q(nib_q), .done(word_done),
      .word_i(word_i), .word_q(word_q));

   always_comb begin
      if (mode == MODE_PACKED) begin
         src_vld  = word_done;
         src_data = {word_i, word_q};
      end else begin
         src_vld  = ddc_valid;
         src_data = {ddc_i, ddc_q};
      end
   end

   word_holder #(.W(WORD_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .src_vld(src_vld), .src_data(src_data),
      .out_ready(out_ready), .ovf_clr(ovf_clr), .out_valid(out_valid),
      .out_data(out_data), .ovf_flag(ovf_flag));

   assert_bypass_pass_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!pack_mode && ddc_valid && (!out_valid || out_ready))
      |=> (out_valid && out_data == $past({ddc_i, ddc_q})));
endmodule

// File: tb/tb_adc_nibble_packer.sv
module tb_adc_nibble_packer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pack_mode = 1'b1;
   logic        start = 1'b0;
   logic [13:0] adc_i = '0, adc_q = '0;
   logic [15:0] ddc_i = '0, ddc_q = '0;
   logic        ddc_valid = 1'b0;
   logic [31:0] out_data;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic        ovf_flag;
   logic        ovf_clr = 1'b0;

   int errors = 0;
   int checks = 0;
   bit done_flag = 0;

   always #2 clk = ~clk;

   adc_nibble_packer dut (
      .clk(clk), .rst_n(rst_n), .pack_mode(pack_mode), .start(start),
      .adc_i(adc_i), .adc_q(adc_q), .ddc_i(ddc_i), .ddc_q(ddc_q),
      .ddc_valid(ddc_valid), .out_data(out_data), .out_valid(out_valid),
      .out_ready(out_ready), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr));

   // behavioural reference model
   logic [3:0] qi[$];
   logic [3:0] qq[$];
   bit          m_valid = 0;
   logic [31:0] m_data = '0;
   bit          m_ovf = 0;

   always @(posedge clk) begin
      bit src;
      logic [31:0] sdata;
      bit held;
      src = 0;
      sdata = '0;
      if (!rst_n) begin
         qi.delete(); qq.delete();
         m_valid = 0; m_data = '0; m_ovf = 0;
      end else begin
         if (pack_mode) begin
            if (start) begin qi.delete(); qq.delete(); end
            qi.push_back(adc_i >> 10);
            qq.push_back(adc_q >> 10);
            if (qi.size() == 4) begin
               src = 1;
               sdata = {qi[0], qi[1], qi[2], qi[3], qq[0], qq[1], qq[2], qq[3]};
               qi.delete(); qq.delete();
            end
         end else begin
            qi.delete(); qq.delete();
            src = ddc_valid;
            sdata = {ddc_i, ddc_q};
         end
         held = m_valid && !out_ready;
         if (src && held) m_ovf = 1;
         else if (ovf_clr) m_ovf = 0;
         if (src && !held) begin m_valid = 1; m_data = sdata; end
         else if (out_ready) m_valid = 0;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         check(out_valid == m_valid, "R4 valid", 32'(out_valid), 32'(m_valid));
         if (m_valid) check(out_data == m_data, "R3 data", out_data, m_data);
         check(ovf_flag == m_ovf, "R9 ovf", 32'(ovf_flag), 32'(m_ovf));
      end
   end

   task automatic drive_pattern(input bit with_start);
      // I nibbles 1,2,3,4 ; Q nibbles 8,9,A,F
      logic [13:0] pi [4] = '{14'h07FF, 14'h0955, 14'h0C00, 14'h13FF};
      logic [13:0] pq [4] = '{14'h2000, 14'h2555, 14'h2BFF, 14'h3FFF};
      for (int n = 0; n < 4; n++) begin
         adc_i = pi[n];
         adc_q = pq[n];
         start = with_start && (n == 0);
         @(negedge clk);
      end
      start = 1'b0;
   endtask

   task automatic random_cycles(input int n, input bit rand_ready);
      for (int c = 0; c < n; c++) begin
         adc_i = 14'($urandom);
         adc_q = 14'($urandom);
         ddc_i = 16'($urandom);
         ddc_q = 16'($urandom);
         ddc_valid = 1'($urandom);
         if (rand_ready) out_ready = ($urandom % 3) != 0;
         ovf_clr = ($urandom % 16) == 0;
         start = ($urandom % 23) == 0;
         @(negedge clk);
      end
      ovf_clr = 1'b0;
      start = 1'b0;
      out_ready = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(out_valid == 1'b0, "R1 valid", 32'(out_valid), 32'h0);
      check(ovf_flag == 1'b0, "R1 ovf", 32'(ovf_flag), 32'h0);
      rst_n = 1'b1;

      random_cycles(40, 0);

      // R2 R3 R5: start mid-stream, fixed pattern with negative codes
      @(negedge clk);
      drive_pattern(1);
      check(out_valid == 1'b1, "R5 valid", 32'(out_valid), 32'h1);
      check(out_data == 32'h1234_89AF, "R2 R3 R5 word", out_data, 32'h1234_89AF);

      // R7 R8: stall and drop
      out_ready = 1'b0;
      drive_pattern(1);
      check(out_data == 32'h1234_89AF, "R7 held", out_data, 32'h1234_89AF);
      adc_i = '0; adc_q = '0;
      repeat (4) @(negedge clk);
      check(out_valid == 1'b1, "R7 still valid", 32'(out_valid), 32'h1);
      check(out_data == 32'h1234_89AF, "R8 kept", out_data, 32'h1234_89AF);
      check(ovf_flag == 1'b1, "R8 ovf set", 32'(ovf_flag), 32'h1);

      // R9 sticky then clear
      out_ready = 1'b1;
      repeat (2) @(negedge clk);
      check(ovf_flag == 1'b1, "R9 sticky", 32'(ovf_flag), 32'h1);
      ovf_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0;
      check(ovf_flag == 1'b0, "R9 cleared", 32'(ovf_flag), 32'h0);

      random_cycles(300, 1);

      // R6 bypass
      pack_mode = 1'b0;
      ddc_valid = 1'b0;
      repeat (2) @(negedge clk);
      ddc_i = 16'hDEAD; ddc_q = 16'hBEEF; ddc_valid = 1'b1;
      @(negedge clk);
      ddc_valid = 1'b0;
      check(out_valid == 1'b1, "R6 valid", 32'(out_valid), 32'h1);
      check(out_data == 32'hDEAD_BEEF, "R6 data", out_data, 32'hDEAD_BEEF);
      random_cycles(60, 1);

      // R10 entering packed mode starts a fresh word
      pack_mode = 1'b0;
      repeat (2) @(negedge clk);
      pack_mode = 1'b1;
      drive_pattern(0);
      check(out_valid == 1'b1, "R10 valid", 32'(out_valid), 32'h1);
      check(out_data == 32'h1234_89AF, "R10 word", out_data, 32'h1234_89AF);
      @(negedge clk);
      check(out_valid == 1'b0, "R4 gap", 32'(out_valid), 32'h0);

      random_cycles(100, 1);
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule